// File: doc/BRIEF.md
# DMA channel load instruction unit

This unit carries out the one-byte load opcode of a single DMA channel thread. When the sequencer presents an opcode with `start`, the unit decodes it. A load may carry an optional qualifier that ties it to the channel's recorded request type, single or burst. If that condition fails, the opcode retires as a no-operation and only the program counter moves on.

If the load runs, the unit issues one AXI read address request built from the source address register and the channel's burst fields. It then passes every returned read beat into a shared data FIFO, tagged with the channel number. It reports the advanced source address and program counter so the channel's registers can be updated.

The request-type flag is only read here. A separate wait-for-peripheral opcode writes it.

Top module: `dma_load_unit`

## Requirements
- R1: An opcode is a load only if bits [7:2] equal 6'b000001 and its bits [1:0] (bit 1 = burst select, bit 0 = qualified) are not 2'b10. On `start` with any other byte, `fault` pulses for exactly the next cycle, and no `arvalid` or `done` follows.
- R2: Loads run in two cases: opcode 8'h04 (unconditional), and opcode 8'h07 (burst-qualified) when `req_burst`=1. The cycle after `start`, such a load raises `arvalid` with `araddr`=`src_addr`, `arlen`=`src_burst_len` and `arsize`=`src_burst_size`.
- R3: Opcode 8'h05 (single-qualified) with `req_burst`=0 runs a load with `arlen`=0, whatever `src_burst_len` holds.
- R4: A qualified opcode whose burst select differs from `req_burst` (8'h05 with `req_burst`=1, 8'h07 with `req_burst`=0) pulses `done` the next cycle. It raises no `arvalid`, `fifo_valid` or `src_we`.
- R5: While read data is expected, `fifo_valid` equals `rvalid`, `rready` equals `fifo_ready`, `fifo_data` equals `rdata`, and `fifo_tag` equals the channel number sampled at `start`.
- R6: One cycle after the address handshake, `src_we` pulses if `src_inc` was set at `start`. With it, `src_addr_nxt` = `araddr` + ((`arlen`+1) << `arsize`). With `src_inc` clear, `src_we` stays low.
- R7: `done` pulses one cycle after a beat with `rlast` is accepted, and not before. Whenever `done` is high, `pc_nxt` equals the `pc` sampled at `start` plus one.
- R8: `arvalid`, `araddr`, `arlen` and `arsize` hold steady until `arready` is seen. The request fields are latched at `start`, so later changes on the inputs do not affect them.
- R9: While `busy` is high, `start` is ignored, and no `fault` or new request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Execute the opcode presented this cycle |
| opcode | input | 8 | Opcode byte |
| req_burst | input | 1 | Recorded request type: 1 burst, 0 single |
| ch_id | input | CH_W | Channel number used as FIFO tag |
| src_inc | input | 1 | Source address increments after the load |
| src_burst_len | input | 4 | Configured beats minus one |
| src_burst_size | input | 3 | Configured log2 bytes per beat |
| src_addr | input | ADDR_W | Source address register |
| pc | input | PC_W | Channel program counter |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Opcode retired; pc_nxt valid |
| fault | output | 1 | Opcode was not a legal load |
| pc_nxt | output | PC_W | Program counter of the next opcode |
| src_we | output | 1 | Write src_addr_nxt into the source address register |
| src_addr_nxt | output | ADDR_W | Advanced source address |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read address |
| arlen | output | 4 | Read length, beats minus one |
| arsize | output | 3 | Read beat size |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DATA_W | Read data |
| rlast | input | 1 | Last read beat |
| fifo_valid | output | 1 | Beat offered to the data FIFO |
| fifo_ready | input | 1 | Data FIFO can accept |
| fifo_data | output | DATA_W | Beat data |
| fifo_tag | output | CH_W | Channel tag of the beat |

## Verification
The bench applies every opcode byte under both request types. A decoder that looked at too few bits, or that accepted the reserved qualifier pair, would start a read or retire an opcode instead of faulting. A unit that confused the qualifier polarity would read on a mismatch or skip a match.

Single-qualified loads are paired with nonzero configured lengths. This catches a design that forwards `src_burst_len` and then waits for too many beats.

Address stalls, FIFO backpressure and input changes after `start` expose a request that is not held, data accepted without room, or a source step computed from the live fields rather than the issued ones. A premature `done` on a non-final beat shows up as a PC update in the middle of a burst.

// File: rtl/dma_load_unit.sv
module dma_load_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CH_W   = 3,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              req_burst,
  input  logic [CH_W-1:0]   ch_id,
  input  logic              src_inc,
  input  logic [3:0]        src_burst_len,
  input  logic [2:0]        src_burst_size,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [PC_W-1:0]   pc,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [PC_W-1:0]   pc_nxt,
  output logic              src_we,
  output logic [ADDR_W-1:0] src_addr_nxt,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  output logic [3:0]        arlen,
  output logic [2:0]        arsize,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rlast,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [DATA_W-1:0] fifo_data,
  output logic [CH_W-1:0]   fifo_tag
);

  typedef enum logic [1:0] {IDLE, ADDR, DATA} state_t;
  state_t state;
  logic   inc_q;

  wire is_load = (opcode[7:2] == 6'b000001);
  wire bsel    = opcode[1];
  wire qual    = opcode[0];
  wire legal   = is_load && !(bsel && !qual);
  wire runs    = !qual || (bsel == req_burst);
  wire [ADDR_W-1:0] step = (ADDR_W'(arlen) + ADDR_W'(1)) << arsize;

  assign busy       = (state != IDLE);
  assign arvalid    = (state == ADDR);
  assign fifo_valid = (state == DATA) && rvalid;
  assign rready     = (state == DATA) && fifo_ready;
  assign fifo_data  = rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= IDLE;
      done         <= 1'b0;
      fault        <= 1'b0;
      src_we       <= 1'b0;
      inc_q        <= 1'b0;
      pc_nxt       <= '0;
      src_addr_nxt <= '0;
      araddr       <= '0;
      arlen        <= '0;
      arsize       <= '0;
      fifo_tag     <= '0;
    end else begin
      done   <= 1'b0;
      fault  <= 1'b0;
      src_we <= 1'b0;
      case (state)
        IDLE: if (start) begin
          if (!legal) begin
            fault <= 1'b1;
          end else if (!runs) begin
            done   <= 1'b1;
            pc_nxt <= pc + PC_W'(1);
          end else begin
            araddr   <= src_addr;
            arlen    <= (qual && !bsel) ? 4'h0 : src_burst_len;
            arsize   <= src_burst_size;
            fifo_tag <= ch_id;
            inc_q    <= src_inc;
            pc_nxt   <= pc + PC_W'(1);
            state    <= ADDR;
          end
        end
        ADDR: if (arready) begin
          state <= DATA;
          if (inc_q) begin
            src_we       <= 1'b1;
            src_addr_nxt <= araddr + step;
          end
        end
        DATA: if (rvalid && fifo_ready && rlast) begin
          done  <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_load_unit_chk.sv
module dma_load_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic [7:0] opcode,
  input logic       req_burst,
  input logic       arvalid,
  input logic       arready,
  input logic [3:0] arlen,
  input logic [2:0] arsize,
  input logic       rvalid,
  input logic       rready,
  input logic       fifo_valid,
  input logic       fifo_ready,
  input logic       done,
  input logic       fault,
  input logic       src_we
);

  wire legal = (opcode[7:2] == 6'b000001) && (opcode[1:0] != 2'b10);

  // R1
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !legal |=> fault && !arvalid && !done);

  // R3
  single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && opcode == 8'h05 && !req_burst |=> arvalid && arlen == 4'h0);

  // R4
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && ((opcode == 8'h05 && req_burst) || (opcode == 8'h07 && !req_burst))
    |=> done && !arvalid && !src_we);

  // R5
  r_to_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rready |-> fifo_valid && fifo_ready);

  // R6
  src_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_we |-> $past(arvalid && arready));

  // R7
  retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault}) && !(done && arvalid));

  // R8
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(arlen) && $stable(arsize));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !fault);

endmodule

bind dma_load_unit dma_load_unit_chk u_chk (
  .clk, .rst_n, .start, .busy, .opcode, .req_burst, .arvalid, .arready,
  .arlen, .arsize, .rvalid, .rready, .fifo_valid, .fifo_ready,
  .done, .fault, .src_we
);

// File: tb/dma_load_unit_tb.sv
module dma_load_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, CW = 3, PW = 32;

  logic clk = 0, rst_n = 0;
  logic start = 0, req_burst = 0, src_inc = 0;
  logic [7:0] opcode = 0;
  logic [CW-1:0] ch_id = 0;
  logic [3:0] src_burst_len = 0;
  logic [2:0] src_burst_size = 0;
  logic [AW-1:0] src_addr = 0;
  logic [PW-1:0] pc = 0;
  logic busy, done, fault, src_we, arvalid, rready, fifo_valid;
  logic [PW-1:0] pc_nxt;
  logic [AW-1:0] src_addr_nxt, araddr;
  logic [3:0] arlen;
  logic [2:0] arsize;
  logic arready = 0, rvalid = 0, rlast = 0, fifo_ready = 0;
  logic [DW-1:0] rdata = 0, fifo_data;
  logic [CW-1:0] fifo_tag;

  int vectors = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_load_unit #(.ADDR_W(AW), .DATA_W(DW), .CH_W(CW), .PC_W(PW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] op, input logic rb, input logic [3:0] len,
                        input logic [2:0] sz, input logic inc, input int ardly, input bit stall,
                        input logic [CW-1:0] ch, input logic [AW-1:0] addr, input logic [PW-1:0] pcv);
    bit legal, runs;
    logic [3:0] elen;
    logic [AW-1:0] enxt;
    legal = (op[7:2] == 6'b000001) && (op[1:0] != 2'b10);
    runs  = !op[0] || (op[1] == rb);
    elen  = (op == 8'h05) ? 4'h0 : len;
    enxt  = addr + ((AW'(elen) + 1) << sz);
    @(negedge clk);
    opcode = op; req_burst = rb; src_burst_len = len; src_burst_size = sz;
    src_inc = inc; ch_id = ch; src_addr = addr; pc = pcv; start = 1;
    @(negedge clk);
    start = 0;
    opcode = 8'hFF; src_addr = ~addr; src_burst_len = ~len; src_burst_size = ~sz; ch_id = ~ch; pc = ~pcv;
    if (!legal) begin
      chk(fault && !arvalid && !done, "R1", {fault, arvalid, done}, 3'b100);
      @(negedge clk);
      chk(!fault && !busy, "R1", {fault, busy}, 2'b00);
    end else if (!runs) begin
      chk(done && !arvalid && !src_we && !fifo_valid, "R4", {done, arvalid, src_we, fifo_valid}, 4'b1000);
      chk(pc_nxt == pcv + 1, "R7", pc_nxt, pcv + 1);
    end else begin
      chk(arvalid && araddr == addr && arsize == sz, "R2", {arvalid, araddr, arsize}, {1'b1, addr, sz});
      chk(arlen == elen, (op == 8'h05) ? "R3" : "R2", arlen, elen);
      for (int d = 0; d < ardly; d++) begin
        if (d == 0) start = 1;
        @(negedge clk);
        start = 0;
        chk(arvalid && araddr == addr && arlen == elen && !fault, "R8", {arvalid, araddr, arlen}, {1'b1, addr, elen});
        if (d == 0) chk(!fault, "R9", fault, 0);
      end
      arready = 1;
      @(negedge clk);
      arready = 0;
      chk(!arvalid, "R8", arvalid, 0);
      chk(src_we == inc, "R6", src_we, inc);
      if (inc) chk(src_addr_nxt == enxt, "R6", src_addr_nxt, enxt);
      for (int b = 0; b <= elen; b++) begin
        if (stall) begin
          rvalid = 1; fifo_ready = 0; rdata = 32'hDEAD0000 | b; rlast = (b == elen);
          #1;
          chk(fifo_valid && !rready, "R5", {fifo_valid, rready}, 2'b10);
          @(negedge clk);
          chk(!done, "R7", done, 0);
        end
        rvalid = 1; fifo_ready = 1; rdata = {addr[15:0], 16'(b)}; rlast = (b == elen);
        #1;
        chk(fifo_valid && rready && fifo_data == rdata && fifo_tag == ch, "R5",
            {fifo_valid, rready, fifo_tag, fifo_data}, {2'b11, ch, rdata});
        @(negedge clk);
        rvalid = 0; fifo_ready = 0; rlast = 0;
        if (b == elen) begin
          chk(done && pc_nxt == pcv + 1, "R7", {done, pc_nxt}, {1'b1, pcv + 1});
        end else begin
          chk(!done, "R7", done, 0);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !arvalid && !src_we && !fifo_valid, "R1 reset",
        {busy, done, fault, arvalid, src_we, fifo_valid}, 0);
    rst_n = 1;
    for (int i = 0; i < 512; i++)
      run_op(8'(i), i[8], 4'(i % 5), 3'(i % 3), (i / 3) % 2 == 1, i % 3, i[0],
             CW'(i), 32'h1000_0000 + 32'(i * 64), 32'(i * 3));
    for (int j = 0; j < 96; j++) begin
      logic [7:0] op;
      op = (j % 3 == 0) ? 8'h04 : (j % 3 == 1) ? 8'h05 : 8'h07;
      run_op(op, (j / 3) % 2 == 1, 4'(j / 6), 3'(j % 3), j[1], j % 2, j[2],
             CW'(j + 1), 32'hFFFF_FF00 + 32'(j * 16), 32'hFFFF_FFF0 + 32'(j));
    end
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule